// File: doc/BRIEF.md
# Load-Use Stall and Flush Controller

This block guards the decode stage of a five-stage in-order pipeline. When the instruction sitting in the decode register reads a register that a load, now one stage ahead in execute, has not yet delivered, the controller holds the fetch address and the decode register for one cycle. In that same cycle it zeroes the control word that is about to enter the execute register, so the slot behind the load carries a bubble. After that single cycle the load has reached memory access, and ordinary forwarding can supply its data.

A taken branch, resolved in decode, also flows through this block. It redirects the fetch address to the supplied target and replaces the decode register's next content with a no-op, which discards the wrongly fetched instruction at a cost of one cycle. The fetch-address register and the decode register are part of the block, so that holding and discarding can be observed cycle by cycle. Computing the branch target and choosing forwarding paths are left to neighbouring logic.

Top module: `lu_stall_ctrl`

## Requirements
- R1: A hazard exists when `exq_is_load` is 1, `exq_dst` is nonzero, and `exq_dst` equals either source field of `ifid_instr` (first source in bits 19:15, second source in bits 24:20). While a hazard exists and `branch_taken` is 0, `pc_we` and `ifid_we` are 0 and `idex_ctrl_zero` is 1 in that same cycle.
- R2: A load whose destination is register 0 never causes a stall, even when a source field of `ifid_instr` is also 0.
- R3: A matching destination with `exq_is_load` at 0 never causes a stall.
- R4: `idex_ctrl_out` is all zeros while `idex_ctrl_zero` is 1. Otherwise it equals `dec_ctrl`.
- R5: Across a clock edge with a stall, `pc_q`, `ifid_instr` and `ifid_pc` keep their values, so the dependent instruction is decoded again and the next one is fetched again.
- R6: Across an edge with no stall and no flush, `pc_q` advances by 4, `ifid_instr` takes `fetch_instr` and `ifid_pc` takes the old `pc_q`.
- R7: While `branch_taken` is 1, `ifid_flush` is 1. At the next edge `pc_q` takes `branch_target` and `ifid_instr` becomes the no-op word 0x00000013.
- R8: When a flush and a hazard coincide, the flush wins: `idex_ctrl_zero` is 0, `pc_we` is 1, and the redirect and discard of R7 take place.
- R9: While reset is asserted, `pc_q` equals `RESET_PC`, `ifid_instr` is 0x00000013 and `ifid_pc` is 0.
- R10: A load followed directly by a dependent instruction costs exactly one stall cycle and one bubble. After that the dependent instruction moves on to execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously inside |
| fetch_instr | input | 32 | Instruction word read at `pc_q` |
| dec_ctrl | input | CTRL_W | Control word that the decoder produced for `ifid_instr` |
| exq_is_load | input | 1 | Execute-stage instruction reads data memory |
| exq_dst | input | 5 | Destination register of the execute-stage instruction |
| branch_taken | input | 1 | Branch in decode is taken this cycle |
| branch_target | input | XLEN | Redirect address for a taken branch |
| pc_q | output | XLEN | Current fetch address |
| ifid_instr | output | 32 | Instruction held in the decode register |
| ifid_pc | output | XLEN | Address of `ifid_instr` |
| pc_we | output | 1 | Fetch address may update this edge |
| ifid_we | output | 1 | Decode register may load this edge |
| idex_ctrl_zero | output | 1 | Bubble: control into execute forced to zero |
| ifid_flush | output | 1 | Decode register is replaced by a no-op this edge |
| idex_ctrl_out | output | CTRL_W | Control word entering the execute register |

## Verification
The stall and flush outputs and `idex_ctrl_out` are combinational, so they are due in the same cycle as the inputs that cause them. The bench drives inputs just after a falling edge and reads these outputs before the next rising edge. `pc_q`, `ifid_instr` and `ifid_pc` change on the rising edge that follows, so each is read after exactly one more edge. The load-use trace runs through a small execute-register model in the bench, which lets the total stall count be compared with the single cycle that R10 requires. After reset is released, the bench waits until `pc_q` first reads 4, which keeps every trace aligned however long the internal reset release takes.

// File: rtl/lu_pkg.sv
package lu_pkg;
  localparam int ILEN = 32;
  localparam int RAW  = 5;
  localparam logic [ILEN-1:0] NOP_WORD = 32'h0000_0013;

  function automatic logic [RAW-1:0] src_a(input logic [ILEN-1:0] w);
    return w[19:15];
  endfunction

  function automatic logic [RAW-1:0] src_b(input logic [ILEN-1:0] w);
    return w[24:20];
  endfunction
endpackage

// File: rtl/lu_rst_sync.sv
module lu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/lu_hazard_unit.sv
module lu_hazard_unit
  import lu_pkg::*;
(
  input  logic            exq_is_load,
  input  logic [RAW-1:0]  exq_dst,
  input  logic [ILEN-1:0] ifid_instr,
  input  logic            branch_taken,
  output logic            stall,
  output logic            flush
);
  logic dst_live;
  logic hit_a;
  logic hit_b;
  logic hazard;

  always_comb begin
    dst_live = (exq_dst != '0);
    hit_a    = (exq_dst == src_a(ifid_instr));
    hit_b    = (exq_dst == src_b(ifid_instr));
    hazard   = exq_is_load && dst_live && (hit_a || hit_b);
    flush    = branch_taken;
    stall    = hazard && !branch_taken;
  end
endmodule

// File: rtl/lu_pc_stage.sv
module lu_pc_stage #(
  parameter int XLEN = 64,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            redirect,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] pc_q
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);
  logic [XLEN-1:0] pc_d;

  always_comb begin
    pc_d = pc_q;
    if (en) pc_d = redirect ? target : pc_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/lu_ifid_stage.sv
module lu_ifid_stage
  import lu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            clear,
  input  logic [ILEN-1:0] instr_in,
  input  logic [XLEN-1:0] pc_in,
  output logic [ILEN-1:0] instr_q,
  output logic [XLEN-1:0] pc_q
);
  logic [ILEN-1:0] instr_d;
  logic [XLEN-1:0] pc_d;

  always_comb begin
    instr_d = instr_q;
    pc_d    = pc_q;
    if (clear) begin
      instr_d = NOP_WORD;
      pc_d    = pc_in;
    end else if (en) begin
      instr_d = instr_in;
      pc_d    = pc_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q <= NOP_WORD;
      pc_q    <= '0;
    end else begin
      instr_q <= instr_d;
      pc_q    <= pc_d;
    end
  end
endmodule

// File: rtl/lu_stall_ctrl.sv
module lu_stall_ctrl
  import lu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int CTRL_W = 8,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ILEN-1:0]   fetch_instr,
  input  logic [CTRL_W-1:0] dec_ctrl,
  input  logic              exq_is_load,
  input  logic [RAW-1:0]    exq_dst,
  input  logic              branch_taken,
  input  logic [XLEN-1:0]   branch_target,
  output logic [XLEN-1:0]   pc_q,
  output logic [ILEN-1:0]   ifid_instr,
  output logic [XLEN-1:0]   ifid_pc,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              idex_ctrl_zero,
  output logic              ifid_flush,
  output logic [CTRL_W-1:0] idex_ctrl_out
);
  logic rst_sync_n;
  logic stall;
  logic flush;

  lu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lu_hazard_unit u_haz (
    .exq_is_load  (exq_is_load),
    .exq_dst      (exq_dst),
    .ifid_instr   (ifid_instr),
    .branch_taken (branch_taken),
    .stall        (stall),
    .flush        (flush)
  );

  always_comb begin
    pc_we          = !stall;
    ifid_we        = !stall;
    idex_ctrl_zero = stall;
    ifid_flush     = flush;
    idex_ctrl_out  = stall ? '0 : dec_ctrl;
  end

  lu_pc_stage #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (pc_we),
    .redirect (flush),
    .target   (branch_target),
    .pc_q     (pc_q)
  );

  lu_ifid_stage #(.XLEN(XLEN)) u_ifid (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (ifid_we),
    .clear    (flush),
    .instr_in (fetch_instr),
    .pc_in    (pc_q),
    .instr_q  (ifid_instr),
    .pc_q     (ifid_pc)
  );
endmodule

// File: rtl/lu_stall_ctrl_chk.sv
module lu_stall_ctrl_chk
  import lu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              exq_is_load,
  input logic [RAW-1:0]    exq_dst,
  input logic              branch_taken,
  input logic [XLEN-1:0]   branch_target,
  input logic [XLEN-1:0]   pc_q,
  input logic [ILEN-1:0]   ifid_instr,
  input logic [XLEN-1:0]   ifid_pc,
  input logic              pc_we,
  input logic              ifid_we,
  input logic              idex_ctrl_zero,
  input logic              ifid_flush,
  input logic [CTRL_W-1:0] idex_ctrl_out
);
  assert_hazard_holds_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    (exq_is_load && exq_dst != '0 && !branch_taken &&
     (exq_dst == ifid_instr[19:15] || exq_dst == ifid_instr[24:20]))
    |-> (!pc_we && !ifid_we && idex_ctrl_zero));

  assert_x0_free_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (exq_dst == '0) |-> (pc_we && !idex_ctrl_zero));

  assert_nonload_free_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    !exq_is_load |-> (pc_we && ifid_we));

  assert_bubble_zero_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    idex_ctrl_zero |-> (idex_ctrl_out == '0));

  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (!pc_we && !ifid_flush) |=> ($stable(pc_q) && $stable(ifid_instr) && $stable(ifid_pc)));

  assert_advance_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (pc_we && !ifid_flush) |=> (pc_q == $past(pc_q) + XLEN'(4) && ifid_pc == $past(pc_q)));

  assert_redirect_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    ifid_flush |=> (pc_q == $past(branch_target) && ifid_instr == NOP_WORD));

  assert_flush_wins_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    branch_taken |-> (ifid_flush && pc_we && !idex_ctrl_zero));
endmodule

bind lu_stall_ctrl lu_stall_ctrl_chk #(.XLEN(XLEN), .CTRL_W(CTRL_W)) u_chk (
  .clk            (clk),
  .rst_ok         (rst_sync_n),
  .exq_is_load    (exq_is_load),
  .exq_dst        (exq_dst),
  .branch_taken   (branch_taken),
  .branch_target  (branch_target),
  .pc_q           (pc_q),
  .ifid_instr     (ifid_instr),
  .ifid_pc        (ifid_pc),
  .pc_we          (pc_we),
  .ifid_we        (ifid_we),
  .idex_ctrl_zero (idex_ctrl_zero),
  .ifid_flush     (ifid_flush),
  .idex_ctrl_out  (idex_ctrl_out)
);

// File: tb/lu_stall_ctrl_test.sv
`timescale 1ns/1ps
module lu_stall_ctrl_test;
  localparam int XLEN = 64;
  localparam int CTRL_W = 8;
  localparam logic [31:0] NOP = 32'h0000_0013;
  localparam logic [CTRL_W-1:0] CTL = 8'hA5;

  logic              clk;
  logic              rst_n;
  logic [31:0]       fetch_instr;
  logic [CTRL_W-1:0] dec_ctrl;
  logic              exq_is_load;
  logic [4:0]        exq_dst;
  logic              branch_taken;
  logic [XLEN-1:0]   branch_target;
  logic [XLEN-1:0]   pc_q;
  logic [31:0]       ifid_instr;
  logic [XLEN-1:0]   ifid_pc;
  logic              pc_we;
  logic              ifid_we;
  logic              idex_ctrl_zero;
  logic              ifid_flush;
  logic [CTRL_W-1:0] idex_ctrl_out;

  logic [31:0] prog [0:15];
  int checks;
  int fails;

  lu_stall_ctrl #(.XLEN(XLEN), .CTRL_W(CTRL_W), .RESET_PC('0)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr), .dec_ctrl(dec_ctrl),
    .exq_is_load(exq_is_load), .exq_dst(exq_dst), .branch_taken(branch_taken),
    .branch_target(branch_target), .pc_q(pc_q), .ifid_instr(ifid_instr),
    .ifid_pc(ifid_pc), .pc_we(pc_we), .ifid_we(ifid_we),
    .idex_ctrl_zero(idex_ctrl_zero), .ifid_flush(ifid_flush),
    .idex_ctrl_out(idex_ctrl_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always_comb fetch_instr = prog[pc_q[5:2]];
  assign dec_ctrl = CTL;

  // execute-register model fed by the decode register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exq_is_load <= 1'b0;
      exq_dst     <= '0;
    end else if (idex_ctrl_zero) begin
      exq_is_load <= 1'b0;
      exq_dst     <= '0;
    end else begin
      exq_is_load <= (ifid_instr[6:0] == 7'b0000011);
      exq_dst     <= ifid_instr[11:7];
    end
  end

  function automatic logic [31:0] ld(input int rd, input int rs);
    return {12'd0, 5'(rs), 3'b011, 5'(rd), 7'b0000011};
  endfunction
  function automatic logic [31:0] add(input int rd, input int ra, input int rb);
    return {7'd0, 5'(rb), 5'(ra), 3'b000, 5'(rd), 7'b0110011};
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // reset, check reset state, release, align to the state after the first fetch
  task automatic start(input logic [31:0] i0, input logic [31:0] i1, input logic [31:0] i2);
    for (int k = 0; k < 16; k++) prog[k] = NOP;
    prog[0] = i0; prog[1] = i1; prog[2] = i2;
    prog[8] = add(20, 21, 22);
    branch_taken  = 1'b0;
    branch_target = '0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 20 && pc_q != 64'd4; k++) step();
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 pc", pc_q, 64'd0);
    chk("R9 instr", {32'd0, ifid_instr}, {32'd0, NOP});
    chk("R9 ifid_pc", ifid_pc, 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_load_use_rs1();
    int stalls;
    start(ld(5, 1), add(6, 5, 2), add(7, 1, 2));
    chk("R6 fetch", {32'd0, ifid_instr}, {32'd0, ld(5, 1)});
    chk("R1 no hazard yet", {63'd0, pc_we}, 64'd1);
    step();
    chk("R1 pc_we", {63'd0, pc_we}, 64'd0);
    chk("R1 ifid_we", {63'd0, ifid_we}, 64'd0);
    chk("R1 zero", {63'd0, idex_ctrl_zero}, 64'd1);
    chk("R4 bubble", {56'd0, idex_ctrl_out}, 64'd0);
    chk("R6 pc", pc_q, 64'd8);
    step();
    chk("R5 pc held", pc_q, 64'd8);
    chk("R5 instr held", {32'd0, ifid_instr}, {32'd0, add(6, 5, 2)});
    chk("R5 ifid_pc held", ifid_pc, 64'd4);
    chk("R4 pass", {56'd0, idex_ctrl_out}, {56'd0, CTL});
    chk("R10 bubble gone", {63'd0, pc_we}, 64'd1);
    step();
    chk("R10 moved on", {32'd0, ifid_instr}, {32'd0, add(7, 1, 2)});
    chk("R10 pc", pc_q, 64'd12);
    start(ld(5, 1), add(6, 5, 2), add(7, 1, 2));
    stalls = 0;
    for (int k = 0; k < 8; k++) begin
      if (idex_ctrl_zero) stalls++;
      step();
    end
    chk("R10 stall count", 64'(stalls), 64'd1);
  endtask

  task automatic t_load_use_rs2();
    start(ld(9, 1), add(6, 2, 9), NOP);
    step();
    chk("R1 rs2 stall", {63'd0, idex_ctrl_zero}, 64'd1);
    chk("R1 rs2 pc_we", {63'd0, pc_we}, 64'd0);
  endtask

  task automatic t_independent();
    int stalls;
    start(ld(5, 1), add(6, 1, 2), add(7, 3, 4));
    stalls = 0;
    for (int k = 1; k <= 6; k++) begin
      if (idex_ctrl_zero) stalls++;
      chk("R6 pc advance", pc_q, 64'(4 * k));
      step();
    end
    chk("R1 independent no stall", 64'(stalls), 64'd0);
  endtask

  task automatic t_x0_load();
    start(ld(0, 1), add(6, 0, 2), NOP);
    step();
    chk("R2 x0 no stall", {63'd0, pc_we}, 64'd1);
    chk("R2 x0 ctrl", {56'd0, idex_ctrl_out}, {56'd0, CTL});
  endtask

  task automatic t_nonload();
    start(add(5, 1, 2), add(6, 5, 2), NOP);
    step();
    chk("R3 nonload no stall", {62'd0, pc_we, ifid_we}, 64'd3);
    step();
    chk("R3 pc", pc_q, 64'd12);
  endtask

  task automatic t_branch();
    start(add(5, 1, 2), add(6, 3, 4), add(7, 1, 1));
    step();
    branch_taken  = 1'b1;
    branch_target = 64'h20;
    #0.1;
    chk("R7 flush", {63'd0, ifid_flush}, 64'd1);
    step();
    branch_taken = 1'b0;
    chk("R7 pc", pc_q, 64'h20);
    chk("R7 nop", {32'd0, ifid_instr}, {32'd0, NOP});
    step();
    chk("R7 target fetched", {32'd0, ifid_instr}, {32'd0, add(20, 21, 22)});
  endtask

  task automatic t_priority();
    start(ld(5, 1), add(6, 5, 2), NOP);
    step();
    branch_taken  = 1'b1;
    branch_target = 64'h20;
    #0.1;
    chk("R8 no bubble", {63'd0, idex_ctrl_zero}, 64'd0);
    chk("R8 pc_we", {63'd0, pc_we}, 64'd1);
    step();
    branch_taken = 1'b0;
    chk("R8 pc", pc_q, 64'h20);
    chk("R8 nop", {32'd0, ifid_instr}, {32'd0, NOP});
  endtask

  initial begin
    checks = 0;
    fails  = 0;
    rst_n  = 1'b0;
    branch_taken  = 1'b0;
    branch_target = '0;
    for (int k = 0; k < 16; k++) prog[k] = NOP;
    t_reset();
    t_load_use_rs1();
    t_load_use_rs2();
    t_independent();
    t_x0_load();
    t_nonload();
    t_branch();
    t_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule